// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This unit sits beside a small store queue in an out-of-order core. When a load issues, it compares the load's sequence number, byte address and size against every store queue entry in the same cycle. It then picks one of three outcomes. It can forward data from a store that fully covers the load. It can send the load back for rescheduling when a store that has not yet written back covers the load only in part. Otherwise the load proceeds to the data cache. The outcome is registered, so each result appears as a single-cycle pulse one clock after the lookup. A forwarded result therefore reaches writeback with a fixed latency of one cycle.

For the partial-overlap case, the unit keeps one stall record. The record holds the sequence number of the load that must be replayed and the sequence number of the store it waits for. If a stall is already recorded, a newly stalling load takes over the record only when it is older. When the recorded store reports that its writeback has completed, the record clears and a replay pulse names the load to run again. The cache, replay scheduling and commit are handled elsewhere.

Top module: `stld_fwd_unit`

## Requirements
- R1: A lookup (`ld_valid` high) produces exactly one of `fwd_valid`, `resched_valid` or `cache_req` on the following cycle, with `res_seq` equal to the load's sequence number. A cycle without a lookup produces none of them on the following cycle.
- R2: A store entry does not take part in the search in any of these cases: `sq_valid` is low, its sequence number is not smaller than the load's, its size is zero, or it is committed.
- R3: Among the participating stores whose byte range intersects the load's range, only the one with the largest sequence number decides the outcome.
- R4: When the deciding store fully covers the load (load_addr >= store_addr and load_addr+load_size <= store_addr+store_size), the result is forward. `fwd_data` is the store data shifted right by 8*(load_addr AND (store_size-1)) bits, with bytes at index load_size and above cleared. Store sizes are 1, 2, 4 or 8 bytes.
- R5: When the deciding store overlaps the load only in part and has not completed its writeback, the result is reschedule.
- R6: When the deciding store overlaps the load only in part and has already completed its writeback, the result is cache. Older stores are not consulted, even one that fully covers the load.
- R7: When no participating store intersects the load, the result is cache.
- R8: A reschedule outcome opens the stall record (`stalled`, `stall_ld_seq`, `stall_st_seq`) on the cycle after the lookup when no stall is open. When a stall is already open, the record is replaced only if the new load's sequence number is smaller; the load and store fields change together.
- R9: While a stall is open, `wb_done` with `wb_seq` equal to `stall_st_seq` clears `stalled` and raises `replay_valid` for one cycle on the next cycle, with `replay_seq` equal to the recorded load. A `wb_done` carrying any other sequence number changes neither.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load issues a lookup this cycle |
| ld_seq | input | SEQ_W | Load sequence number |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes |
| sq_valid | input | DEPTH | Store entry occupied |
| sq_seq | input | DEPTH x SEQ_W | Store sequence numbers |
| sq_addr | input | DEPTH x ADDR_W | Store byte addresses |
| sq_size | input | DEPTH x SIZE_W | Store sizes in bytes, zero when data is not yet written |
| sq_data | input | DEPTH x DATA_W | Store data, byte 0 in the low bits |
| sq_committed | input | DEPTH | Store has committed |
| sq_completed | input | DEPTH | Store has written back |
| wb_done | input | 1 | A store finished its writeback |
| wb_seq | input | SEQ_W | Sequence number of that store |
| fwd_valid | output | 1 | Forward outcome pulse |
| resched_valid | output | 1 | Reschedule outcome pulse |
| cache_req | output | 1 | Cache access outcome pulse (one port used) |
| res_seq | output | SEQ_W | Load sequence number for the outcome |
| fwd_data | output | DATA_W | Aligned forwarded data |
| stalled | output | 1 | Stall record open |
| stall_ld_seq | output | SEQ_W | Recorded stalled load |
| stall_st_seq | output | SEQ_W | Store the stall waits for |
| replay_valid | output | 1 | Replay pulse for the recorded load |
| replay_seq | output | SEQ_W | Load to replay |

## Verification
On every cycle, the assertions check three things. Outcome pulses are one-hot and follow a lookup one cycle later. An open stall persists, and its load sequence number never grows, until a writeback arrives. A replay only follows an open stall. The choice of store itself can only be shown by the bench's scenarios, which compare outcomes against a reference search. These scenarios cover the youngest-older priority, the skipping rules, the shifted and masked forward data, and an early end on a completed partial store. The bench also checks the replacement rule between competing stalled loads and release on a matching or mismatching writeback.

// File: rtl/stld_pkg.sv
package stld_pkg;
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_FWD   = 2'd1,
        RES_STALL = 2'd2,
        RES_CACHE = 2'd3
    } res_kind_e;
endpackage

// File: rtl/stld_entry_cmp.sv
// Classifies one store entry against the issuing load.
module stld_entry_cmp #(
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 4
) (
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              st_committed,
    output logic              hits,
    output logic              covers
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] l_lo, l_hi, s_lo, s_hi;
    logic             takes_part, intersects;

    always_comb begin
        l_lo = {1'b0, ld_addr};
        s_lo = {1'b0, st_addr};
        l_hi = l_lo + EXT_W'(ld_size);
        s_hi = s_lo + EXT_W'(st_size);
        // R2: skipped entries never reach the comparison
        takes_part = st_valid && (st_seq < ld_seq) &&
                     (st_size != '0) && !st_committed;
        intersects = (l_lo < s_hi) && (l_hi > s_lo);
        hits       = takes_part && intersects;
        covers     = (l_lo >= s_lo) && (l_hi <= s_hi);
    end
endmodule

// File: rtl/stld_pick.sv
// Chooses the intersecting store with the largest sequence number.
module stld_pick #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!found || (seq[i] > best_seq))) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_seq = seq[i];
            end
        end
    end
endmodule

// File: rtl/stld_align.sv
// Shifts store data to the load's offset and keeps only the load's bytes.
module stld_align #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [DATA_W-1:0] st_data,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    output logic [DATA_W-1:0] out_data
);
    logic [SIZE_W-1:0] size_m1;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        size_m1 = st_size - SIZE_W'(1);
        off     = ld_addr[OFF_W-1:0] & size_m1[OFF_W-1:0];
        shifted = st_data >> {off, 3'b000};
        for (int b = 0; b < BYTES; b++) begin
            out_data[b*8 +: 8] = (int'(ld_size) > b) ? shifted[b*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/stld_stall_ctl.sv
// Stall record: oldest stalled load, the store it waits on, and the replay pulse.
module stld_stall_ctl #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_stall,
    input  logic [SEQ_W-1:0] new_ld_seq,
    input  logic [SEQ_W-1:0] new_st_seq,
    input  logic             wb_done,
    input  logic [SEQ_W-1:0] wb_seq,
    output logic             stalled,
    output logic [SEQ_W-1:0] stall_ld_seq,
    output logic [SEQ_W-1:0] stall_st_seq,
    output logic             replay_valid,
    output logic [SEQ_W-1:0] replay_seq
);
    typedef struct packed {
        logic             open;
        logic [SEQ_W-1:0] ld;
        logic [SEQ_W-1:0] st;
        logic             rep;
        logic [SEQ_W-1:0] rep_seq;
    } rec_t;

    rec_t rec_d, rec_q;
    logic release_now;

    always_comb begin
        rec_d       = rec_q;
        rec_d.rep   = 1'b0;
        release_now = rec_q.open && wb_done && (wb_seq == rec_q.st);
        if (release_now) begin
            rec_d.open    = 1'b0;
            rec_d.rep     = 1'b1;
            rec_d.rep_seq = rec_q.ld;
        end
        if (new_stall && (!rec_d.open || (new_ld_seq < rec_q.ld))) begin
            rec_d.open = 1'b1;
            rec_d.ld   = new_ld_seq;
            rec_d.st   = new_st_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign stalled      = rec_q.open;
    assign stall_ld_seq = rec_q.ld;
    assign stall_st_seq = rec_q.st;
    assign replay_valid = rec_q.rep;
    assign replay_seq   = rec_q.rep_seq;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !wb_done) |=> stalled);
    // R8
    oldest_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !wb_done) |=> (stall_ld_seq <= $past(stall_ld_seq)));
    // R9
    replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> $past(stalled));
endmodule

// File: rtl/stld_fwd_unit.sv
module stld_fwd_unit #(
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_valid,
    input  logic [SEQ_W-1:0]             ld_seq,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [SIZE_W-1:0]            ld_size,
    input  logic [DEPTH-1:0]             sq_valid,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  sq_seq,
    input  logic [DEPTH-1:0][ADDR_W-1:0] sq_addr,
    input  logic [DEPTH-1:0][SIZE_W-1:0] sq_size,
    input  logic [DEPTH-1:0][DATA_W-1:0] sq_data,
    input  logic [DEPTH-1:0]             sq_committed,
    input  logic [DEPTH-1:0]             sq_completed,
    input  logic                         wb_done,
    input  logic [SEQ_W-1:0]             wb_seq,
    output logic                         fwd_valid,
    output logic                         resched_valid,
    output logic                         cache_req,
    output logic [SEQ_W-1:0]             res_seq,
    output logic [DATA_W-1:0]            fwd_data,
    output logic                         stalled,
    output logic [SEQ_W-1:0]             stall_ld_seq,
    output logic [SEQ_W-1:0]             stall_st_seq,
    output logic                         replay_valid,
    output logic [SEQ_W-1:0]             replay_seq
);
    import stld_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        res_kind_e         kind;
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
    } res_t;

    logic [DEPTH-1:0] hit_vec, cov_vec;
    logic             found;
    logic [IDX_W-1:0] sel;
    logic [DATA_W-1:0] aligned;
    res_t res_d, res_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        stld_entry_cmp #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
            .ld_seq      (ld_seq),
            .ld_addr     (ld_addr),
            .ld_size     (ld_size),
            .st_valid    (sq_valid[g]),
            .st_seq      (sq_seq[g]),
            .st_addr     (sq_addr[g]),
            .st_size     (sq_size[g]),
            .st_committed(sq_committed[g]),
            .hits        (hit_vec[g]),
            .covers      (cov_vec[g])
        );
    end

    // R3: youngest intersecting older store wins
    stld_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
        .cand (hit_vec),
        .seq  (sq_seq),
        .found(found),
        .idx  (sel)
    );

    stld_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_align (
        .st_data (sq_data[sel]),
        .st_size (sq_size[sel]),
        .ld_addr (ld_addr),
        .ld_size (ld_size),
        .out_data(aligned)
    );

    always_comb begin
        res_d.kind = RES_NONE;
        res_d.seq  = '0;
        res_d.data = '0;
        if (ld_valid) begin
            res_d.seq = ld_seq;
            if (!found) begin
                res_d.kind = RES_CACHE;              // R7
            end else if (cov_vec[sel]) begin
                res_d.kind = RES_FWD;                // R4
                res_d.data = aligned;
            end else if (sq_completed[sel]) begin
                res_d.kind = RES_CACHE;              // R6
            end else begin
                res_d.kind = RES_STALL;              // R5
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q.kind <= RES_NONE;
            res_q.seq  <= '0;
            res_q.data <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    stld_stall_ctl #(.SEQ_W(SEQ_W)) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_stall   (res_d.kind == RES_STALL),
        .new_ld_seq  (ld_seq),
        .new_st_seq  (sq_seq[sel]),
        .wb_done     (wb_done),
        .wb_seq      (wb_seq),
        .stalled     (stalled),
        .stall_ld_seq(stall_ld_seq),
        .stall_st_seq(stall_st_seq),
        .replay_valid(replay_valid),
        .replay_seq  (replay_seq)
    );

    assign fwd_valid     = (res_q.kind == RES_FWD);
    assign resched_valid = (res_q.kind == RES_STALL);
    assign cache_req     = (res_q.kind == RES_CACHE);
    assign res_seq       = res_q.seq;
    assign fwd_data      = res_q.data;

    // R1
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ($countones({fwd_valid, resched_valid, cache_req}) == 1));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !(fwd_valid || resched_valid || cache_req));
    // R1
    seq_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (res_seq == $past(ld_seq)));
endmodule

// File: tb/stld_fwd_unit_test.sv
module stld_fwd_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic [15:0] ld_seq = '0, ld_addr = '0, wb_seq = '0;
    logic [3:0] ld_size = '0;
    logic [D-1:0] sq_valid = '0, sq_committed = '0, sq_completed = '0;
    logic [D-1:0][15:0] sq_seq = '0, sq_addr = '0;
    logic [D-1:0][3:0] sq_size = '0;
    logic [D-1:0][63:0] sq_data = '0;
    logic wb_done = 1'b0;
    logic fwd_valid, resched_valid, cache_req, stalled, replay_valid;
    logic [15:0] res_seq, stall_ld_seq, stall_st_seq, replay_seq;
    logic [63:0] fwd_data;

    int checks = 0, errors = 0, cycles = 0;
    logic m_open = 1'b0;
    logic [15:0] m_ld = '0, m_st = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stld_fwd_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seq(ld_seq),
        .ld_addr(ld_addr), .ld_size(ld_size), .sq_valid(sq_valid),
        .sq_seq(sq_seq), .sq_addr(sq_addr), .sq_size(sq_size),
        .sq_data(sq_data), .sq_committed(sq_committed),
        .sq_completed(sq_completed), .wb_done(wb_done), .wb_seq(wb_seq),
        .fwd_valid(fwd_valid), .resched_valid(resched_valid),
        .cache_req(cache_req), .res_seq(res_seq), .fwd_data(fwd_data),
        .stalled(stalled), .stall_ld_seq(stall_ld_seq),
        .stall_st_seq(stall_st_seq), .replay_valid(replay_valid),
        .replay_seq(replay_seq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 forward, 2 reschedule, 3 cache
    function automatic void ref_lookup(input logic [15:0] s, input logic [15:0] a,
                                       input logic [3:0] z, output int kind,
                                       output logic [63:0] data, output logic [15:0] sst);
        int best = -1;
        data = '0;
        sst  = '0;
        for (int i = 0; i < D; i++) begin
            if (sq_valid[i] && sq_seq[i] < s && sq_size[i] != 0 && !sq_committed[i] &&
                int'(a) < int'(sq_addr[i]) + int'(sq_size[i]) &&
                int'(a) + int'(z) > int'(sq_addr[i])) begin
                if (best < 0 || sq_seq[i] > sq_seq[best]) best = i;
            end
        end
        if (best < 0) kind = 3;
        else if (int'(a) >= int'(sq_addr[best]) &&
                 int'(a) + int'(z) <= int'(sq_addr[best]) + int'(sq_size[best])) begin
            int off = (int'(a) & (int'(sq_size[best]) - 1)) & 7;
            logic [63:0] sh = sq_data[best] >> (off * 8);
            kind = 1;
            for (int b = 0; b < 8; b++) if (b < int'(z)) data[b*8 +: 8] = sh[b*8 +: 8];
        end else if (sq_completed[best]) kind = 3;
        else begin
            kind = 2;
            sst  = sq_seq[best];
        end
    endfunction

    task automatic set_store(int i, logic v, logic [15:0] s, logic [15:0] a, logic [3:0] z,
                             logic [63:0] d, logic com, logic cpl);
        sq_valid[i] = v; sq_seq[i] = s; sq_addr[i] = a; sq_size[i] = z;
        sq_data[i] = d; sq_committed[i] = com; sq_completed[i] = cpl;
    endtask

    task automatic step(string req, logic lv, logic [15:0] s, logic [15:0] a, logic [3:0] z,
                        logic wb, logic [15:0] ws);
        int kind = 0;
        logic [63:0] data = '0;
        logic [15:0] sst = '0;
        logic exp_rep;
        logic [15:0] exp_rseq;
        ld_valid = lv; ld_seq = s; ld_addr = a; ld_size = z;
        wb_done = wb; wb_seq = ws;
        if (lv) ref_lookup(s, a, z, kind, data, sst);
        exp_rep  = m_open && wb && (ws == m_st);
        exp_rseq = m_ld;
        if (exp_rep) m_open = 1'b0;
        if (kind == 2 && (!m_open || s < m_ld)) begin
            m_open = 1'b1; m_ld = s; m_st = sst;
        end
        @(negedge clk);
        chk({req, " R1 fwd"},  64'(fwd_valid), 64'(kind == 1));
        chk({req, " R5 resched"}, 64'(resched_valid), 64'(kind == 2));
        chk({req, " R7 cache"}, 64'(cache_req), 64'(kind == 3));
        if (lv) chk({req, " R1 seq"}, 64'(res_seq), 64'(s));
        if (kind == 1) chk({req, " R4 data"}, fwd_data, data);
        chk({req, " R8 stalled"}, 64'(stalled), 64'(m_open));
        if (m_open) begin
            chk({req, " R8 ld"}, 64'(stall_ld_seq), 64'(m_ld));
            chk({req, " R8 st"}, 64'(stall_st_seq), 64'(m_st));
        end
        chk({req, " R9 replay"}, 64'(replay_valid), 64'(exp_rep));
        if (exp_rep) chk({req, " R9 rseq"}, 64'(replay_seq), 64'(exp_rseq));
        ld_valid = 1'b0; wb_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 outs", {fwd_valid, resched_valid, cache_req, stalled, replay_valid}, 0);
        chk("R10 data", fwd_data, 0);
        chk("R10 seqs", {res_seq, stall_ld_seq, stall_st_seq, replay_seq}, 0);

        // R4: shifted, masked forward
        set_store(0, 1, 16'd10, 16'h10, 4'd8, 64'h8877665544332211, 0, 0);
        step("R4 shift", 1, 16'd20, 16'h12, 4'd2, 0, 0);
        // R2: store younger than load is ignored
        step("R2 younger", 1, 16'd5, 16'h12, 4'd2, 0, 0);
        // R2: committed store is ignored
        sq_committed[0] = 1'b1;
        step("R2 committed", 1, 16'd20, 16'h12, 4'd2, 0, 0);
        sq_committed[0] = 1'b0;
        // R2: zero-size store is ignored
        set_store(1, 1, 16'd12, 16'h10, 4'd0, 64'hFF, 0, 0);
        step("R2 size0", 1, 16'd20, 16'h10, 4'd1, 0, 0);
        // R3: younger of two covering stores wins
        set_store(1, 1, 16'd12, 16'h10, 4'd4, 64'hAABBCCDD, 0, 0);
        step("R3 youngest", 1, 16'd20, 16'h11, 4'd1, 0, 0);
        // R6: completed partial store ends the search
        set_store(1, 1, 16'd12, 16'h14, 4'd4, 64'h1, 0, 1);
        step("R6 done partial", 1, 16'd20, 16'h10, 4'd8, 0, 0);
        // R5, R8: partial store pending -> stall recorded
        sq_completed[1] = 1'b0;
        step("R5 stall", 1, 16'd20, 16'h10, 4'd8, 0, 0);
        // R8: older load replaces, younger does not
        step("R8 older", 1, 16'd15, 16'h10, 4'd8, 0, 0);
        step("R8 younger", 1, 16'd18, 16'h10, 4'd8, 0, 0);
        // R9: mismatching writeback, then matching one
        step("R9 wrong", 0, 0, 0, 0, 1, 16'd10);
        step("R9 match", 0, 0, 0, 0, 1, 16'd12);
        // R7: no overlap
        step("R7 miss", 1, 16'd20, 16'h40, 4'd4, 0, 0);

        for (int n = 0; n < 600; n++) begin
            logic flip = 1'($urandom % 2);
            logic [15:0] la, ls, ws;
            logic [3:0] lz;
            for (int i = 0; i < D; i++) begin
                int z = 1 << ($urandom % 4);
                int slot = flip ? (D - 1 - i) : i;
                set_store(slot, ($urandom % 8) != 0, 16'(i * 5 + $urandom % 5),
                          16'(($urandom % 32) & ~(z - 1)),
                          ($urandom % 8 == 0) ? 4'd0 : 4'(z),
                          {$urandom, $urandom}, ($urandom % 8) == 0, ($urandom % 4) == 0);
            end
            lz = 4'(1 << ($urandom % 3));
            la = 16'(($urandom % 32) & ~(int'(lz) - 1));
            ls = 16'($urandom % 23);
            ws = ($urandom % 2 != 0) ? m_st : 16'($urandom % 23);
            step("RND", ($urandom % 8) != 0, ls, la, lz, ($urandom % 4) == 0, ws);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule